// File: doc/BRIEF.md
# Two-Bank Multiplexed Latch Transceiver

This block joins one host-side port to two bank-side ports of equal width. It lets a shared address or data bus be split across an even and an odd memory bank, or merged back. Four transparent latches sit inside it. Two carry host data out to the banks. Two carry bank data back to the host. A select input picks which of the two returning latches drives the host port. Each port has its own active-low output enable.

Every bidirectional pin is modelled as three signals:
- an input vector, together with a flag saying whether something outside drives it;
- an output vector;
- a one-bit output enable.

A per-port keeper register holds the last driven level, so an undriven port never floats.

Each latch is modelled in the clock domain. While its enable is high, the latch output follows its input in the same cycle. At every rising clock edge where the enable is high, the latch stores its input. Once the enable is low, the latch keeps showing the value it stored at the last such edge.

Top module: `bank_mux_latch`

## Requirements
- R1: After reset, every latch holds zero. With all latch enables low and all output enables asserted, every port output reads 0x000.
- R2: While a host-to-bank latch enable is high, that bank's output equals the host pin value in the same cycle.
- R3: After a host-to-bank latch enable goes low, the bank output keeps the host pin value from the last clock edge at which the enable was high, whatever the host pin does afterwards.
- R4: The bank-to-host latches behave the same way. They are transparent while their enable is high and hold the last value stored while it was high.
- R5: When `sel` is 1, the bank-1 return latch drives the host port. When `sel` is 0, the bank-2 return latch drives it.
- R6: Each `*_oe_n` input is active low. When it is 1, that port's `*_oe` output is 0 and its `*_out` is 0x000, which stands for high impedance.
- R7: The two bank enables act independently. Bank 1, bank 2, both or neither can drive at once.
- R8: When the outside driver of a port lets go, the port's pin value keeps the last externally driven value. Latches fed from that pin see the kept value.
- R9: When a port drives itself and no outside driver is active, its keeper takes the port's own output. After the port's output enable is then released, the kept pin value equals that last output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch storage and keepers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 12 | Host pin value from outside |
| a_in_drv | input | 1 | Outside driver on host pin active |
| a_out | output | 12 | Host pin drive value |
| a_oe | output | 1 | Host pin driver enable |
| b1_in | input | 12 | Bank-1 pin value from outside |
| b1_in_drv | input | 1 | Outside driver on bank-1 pin active |
| b1_out | output | 12 | Bank-1 pin drive value |
| b1_oe | output | 1 | Bank-1 pin driver enable |
| b2_in | input | 12 | Bank-2 pin value from outside |
| b2_in_drv | input | 1 | Outside driver on bank-2 pin active |
| b2_out | output | 12 | Bank-2 pin drive value |
| b2_oe | output | 1 | Bank-2 pin driver enable |
| le_a2b1 | input | 1 | Host-to-bank-1 latch enable |
| le_a2b2 | input | 1 | Host-to-bank-2 latch enable |
| le_b12a | input | 1 | Bank-1-to-host latch enable |
| le_b22a | input | 1 | Bank-2-to-host latch enable |
| sel | input | 1 | Return path select, 1 = bank 1 |
| a_oe_n | input | 1 | Host output enable, active low |
| b1_oe_n | input | 1 | Bank-1 output enable, active low |
| b2_oe_n | input | 1 | Bank-2 output enable, active low |

## Verification
The hardest case to reach from the ports is the keeper on a port holding its own driven value (R9). The stimulus first captures distinct values in a return latch while the bank drives from outside. It then lets the host port drive with no outside driver, and finally releases both the host enable and the bank driver. After that, a host-to-bank latch is opened, and the value it shows reveals the kept pin level. The whole run ends with a sweep over all sixteen combinations of `sel` and the three enables, with every latch closed on distinct contents.

// File: rtl/bml_pkg.sv
package bml_pkg;
    typedef enum logic {
        SRC_BANK2 = 1'b0,
        SRC_BANK1 = 1'b1
    } src_e;
    localparam int NUM_BANKS = 2;
endpackage

// File: rtl/bml_latch.sv
module bml_latch #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] held;

    // store on every edge while open; closing keeps the last stored word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  held <= '0;
        else if (le) held <= d;
    end

    always_comb begin
        q = le ? d : held;
    end
endmodule

// File: rtl/bml_pad.sv
module bml_pad #(
    parameter int WIDTH = 12,
    parameter bit KEEP  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ext_d,
    input  logic             ext_drv,
    input  logic [WIDTH-1:0] own_d,
    input  logic             own_oe,
    output logic [WIDTH-1:0] pin
);
    generate
        if (KEEP) begin : g_keep
            logic [WIDTH-1:0] keep_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       keep_q <= '0;
                else if (ext_drv) keep_q <= ext_d;
                else if (own_oe)  keep_q <= own_d;
            end
            assign pin = ext_drv ? ext_d : keep_q;
        end else begin : g_float
            assign pin = ext_drv ? ext_d : '0;
        end
    endgenerate
endmodule

// File: rtl/bank_mux_latch.sv
module bank_mux_latch #(
    parameter int WIDTH = 12,
    parameter bit KEEP  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             a_in_drv,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b1_in,
    input  logic             b1_in_drv,
    output logic [WIDTH-1:0] b1_out,
    output logic             b1_oe,
    input  logic [WIDTH-1:0] b2_in,
    input  logic             b2_in_drv,
    output logic [WIDTH-1:0] b2_out,
    output logic             b2_oe,
    input  logic             le_a2b1,
    input  logic             le_a2b2,
    input  logic             le_b12a,
    input  logic             le_b22a,
    input  logic             sel,
    input  logic             a_oe_n,
    input  logic             b1_oe_n,
    input  logic             b2_oe_n
);
    import bml_pkg::*;
    localparam int NB = NUM_BANKS;

    logic [WIDTH-1:0] a_pin;
    logic [WIDTH-1:0] b_ext    [NB];
    logic             b_drv    [NB];
    logic [WIDTH-1:0] b_pin    [NB];
    logic [WIDTH-1:0] to_bank  [NB];
    logic [WIDTH-1:0] from_bank[NB];
    logic [WIDTH-1:0] b_drive  [NB];
    logic             le_out   [NB];
    logic             le_ret   [NB];
    logic             b_en     [NB];
    src_e             a_src;
    logic [WIDTH-1:0] a_mux;

    assign b_ext[0]  = b1_in;
    assign b_ext[1]  = b2_in;
    assign b_drv[0]  = b1_in_drv;
    assign b_drv[1]  = b2_in_drv;
    assign le_out[0] = le_a2b1;
    assign le_out[1] = le_a2b2;
    assign le_ret[0] = le_b12a;
    assign le_ret[1] = le_b22a;
    assign b_en[0]   = ~b1_oe_n;
    assign b_en[1]   = ~b2_oe_n;

    // host pin: own drive feeds only the keeper, so no combinational loop
    bml_pad #(.WIDTH(WIDTH), .KEEP(KEEP)) u_pad_a (
        .clk(clk), .rst_n(rst_n), .ext_d(a_in), .ext_drv(a_in_drv),
        .own_d(a_out), .own_oe(a_oe), .pin(a_pin)
    );

    generate
        for (genvar g = 0; g < NB; g++) begin : g_bank
            bml_pad #(.WIDTH(WIDTH), .KEEP(KEEP)) u_pad (
                .clk(clk), .rst_n(rst_n), .ext_d(b_ext[g]), .ext_drv(b_drv[g]),
                .own_d(b_drive[g]), .own_oe(b_en[g]), .pin(b_pin[g])
            );
            bml_latch #(.WIDTH(WIDTH)) u_out (
                .clk(clk), .rst_n(rst_n), .le(le_out[g]), .d(a_pin), .q(to_bank[g])
            );
            bml_latch #(.WIDTH(WIDTH)) u_ret (
                .clk(clk), .rst_n(rst_n), .le(le_ret[g]), .d(b_pin[g]), .q(from_bank[g])
            );
            assign b_drive[g] = b_en[g] ? to_bank[g] : '0;
        end
    endgenerate

    always_comb begin
        a_src = sel ? SRC_BANK1 : SRC_BANK2;
        unique case (a_src)
            SRC_BANK1: a_mux = from_bank[0];
            SRC_BANK2: a_mux = from_bank[1];
        endcase
    end

    assign a_oe   = ~a_oe_n;
    assign a_out  = a_oe ? a_mux : '0;
    assign b1_oe  = b_en[0];
    assign b2_oe  = b_en[1];
    assign b1_out = b_drive[0];
    assign b2_out = b_drive[1];
endmodule

// File: rtl/bml_checker.sv
module bml_checker #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic             a_in_drv,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b1_in,
    input logic             b1_in_drv,
    input logic [WIDTH-1:0] b1_out,
    input logic             b1_oe,
    input logic [WIDTH-1:0] b2_in,
    input logic             b2_in_drv,
    input logic [WIDTH-1:0] b2_out,
    input logic             b2_oe,
    input logic             le_a2b1,
    input logic             le_a2b2,
    input logic             le_b12a,
    input logic             le_b22a,
    input logic             sel,
    input logic             a_oe_n,
    input logic             b1_oe_n,
    input logic             b2_oe_n
);
    p_pass_b1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (le_a2b1 && !b1_oe_n && a_in_drv) |-> (b1_out == a_in));

    p_pass_b2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (le_a2b2 && !b2_oe_n && a_in_drv) |-> (b2_out == a_in));

    p_hold_b1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_a2b1 && !b1_oe_n && $past(!le_a2b1 && !b1_oe_n)) |-> $stable(b1_out));

    p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_b12a && !le_b22a && !a_oe_n && $stable(sel)
         && $past(!le_b12a && !le_b22a && !a_oe_n)) |-> $stable(a_out));

    p_sel_b1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !a_oe_n && le_b12a && b1_in_drv) |-> (a_oe && a_out == b1_in));

    p_sel_b2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !a_oe_n && le_b22a && b2_in_drv) |-> (a_oe && a_out == b2_in));

    p_off_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe_n |-> (!a_oe && a_out == '0));

    p_off_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_oe_n |-> (!b1_oe && b1_out == '0)) and (b2_oe_n |-> (!b2_oe && b2_out == '0)));

    p_keep_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_in_drv) && !a_in_drv && le_a2b1 && !b1_oe_n)
        |-> (b1_out == $past(a_in)));
endmodule

bind bank_mux_latch bml_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bank_mux_latch_tb.sv
module bank_mux_latch_tb;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic a_in_drv = 1'b0, b1_in_drv = 1'b0, b2_in_drv = 1'b0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic a_oe, b1_oe, b2_oe;
    logic le_a2b1 = 1'b0, le_a2b2 = 1'b0, le_b12a = 1'b0, le_b22a = 1'b0;
    logic sel = 1'b1;
    logic a_oe_n = 1'b1, b1_oe_n = 1'b1, b2_oe_n = 1'b1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      rid;
        int         port;
        logic [W-1:0] val;
        logic       oe;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    bank_mux_latch u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_in_drv(a_in_drv), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_in_drv(b1_in_drv), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_in(b2_in), .b2_in_drv(b2_in_drv), .b2_out(b2_out), .b2_oe(b2_oe),
        .le_a2b1(le_a2b1), .le_a2b2(le_a2b2), .le_b12a(le_b12a), .le_b22a(le_b22a),
        .sel(sel), .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n)
    );

    task automatic want(input string rid, input int port, input logic [W-1:0] val, input logic oe);
        exp_t e;
        e.rid = rid; e.port = port; e.val = val; e.oe = oe;
        sb.push_back(e);
    endtask

    task automatic want_all(input string rid, input logic [W-1:0] va, input logic oa,
                            input logic [W-1:0] v1, input logic o1,
                            input logic [W-1:0] v2, input logic o2);
        want(rid, 0, va, oa);
        want(rid, 1, v1, o1);
        want(rid, 2, v2, o2);
    endtask

    // monitor: compares queued expectations shortly after each drive point
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                logic [W-1:0] av;
                logic ao;
                e = sb.pop_front();
                case (e.port)
                    0: begin av = a_out;  ao = a_oe;  end
                    1: begin av = b1_out; ao = b1_oe; end
                    default: begin av = b2_out; ao = b2_oe; end
                endcase
                checks++;
                if (av !== e.val || ao !== e.oe) begin
                    failures++;
                    $display("FAIL %s port%0d: got out=%h oe=%b, expected out=%h oe=%b",
                             e.rid, e.port, av, ao, e.val, e.oe);
                end
            end
            if (rst_n) begin
                checks++;
                if ((a_oe && a_in_drv) || (b1_oe && b1_in_drv) || (b2_oe && b2_in_drv)) begin
                    failures++;
                    $display("FAIL R6 contention: got oe=%b%b%b drv=%b%b%b, expected no overlap",
                             a_oe, b1_oe, b2_oe, a_in_drv, b1_in_drv, b2_in_drv);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        want_all("R6", '0, 1'b0, '0, 1'b0, '0, 1'b0);

        @(negedge clk);
        a_oe_n = 1'b0; b1_oe_n = 1'b0; b2_oe_n = 1'b0;
        want_all("R1", '0, 1'b1, '0, 1'b1, '0, 1'b1);

        // host to bank 1 transparency, then capture
        @(negedge clk);
        a_oe_n = 1'b1; b2_oe_n = 1'b1;
        a_in = 12'hA5A; a_in_drv = 1'b1; le_a2b1 = 1'b1;
        want("R2", 1, 12'hA5A, 1'b1);
        @(negedge clk);
        a_in = 12'h3C3;
        want("R2", 1, 12'h3C3, 1'b1);
        @(negedge clk);
        le_a2b1 = 1'b0; a_in = 12'h0F0;
        want("R3", 1, 12'h3C3, 1'b1);
        @(negedge clk);
        a_in = 12'hFFF;
        want("R3", 1, 12'h3C3, 1'b1);

        // bank 2 joins: both banks driven
        @(negedge clk);
        le_a2b2 = 1'b1; b2_oe_n = 1'b0;
        want("R7", 2, 12'hFFF, 1'b1);
        want("R7", 1, 12'h3C3, 1'b1);
        @(negedge clk);
        le_a2b2 = 1'b0; a_in = 12'h123;
        want("R3", 2, 12'hFFF, 1'b1);
        want("R7", 1, 12'h3C3, 1'b1);

        // bank to host return paths
        @(negedge clk);
        b1_oe_n = 1'b1; b2_oe_n = 1'b1; a_in_drv = 1'b0;
        b1_in = 12'h456; b1_in_drv = 1'b1; le_b12a = 1'b1; sel = 1'b1; a_oe_n = 1'b0;
        want_all("R4", 12'h456, 1'b1, '0, 1'b0, '0, 1'b0);
        @(negedge clk);
        b2_in = 12'h789; b2_in_drv = 1'b1; le_b22a = 1'b1; sel = 1'b0;
        want("R5", 0, 12'h789, 1'b1);
        @(negedge clk);
        le_b12a = 1'b0; le_b22a = 1'b0; b1_in = 12'h000; b2_in = 12'h001;
        want("R4", 0, 12'h789, 1'b1);
        @(negedge clk);
        sel = 1'b1;
        want("R5", 0, 12'h456, 1'b1);

        // host keeper took its own driven word
        @(negedge clk);
        a_oe_n = 1'b1; b1_in_drv = 1'b0; b2_in_drv = 1'b0;
        le_a2b1 = 1'b1; b1_oe_n = 1'b0;
        want("R9", 1, 12'h456, 1'b1);
        want("R6", 0, '0, 1'b0);
        @(negedge clk);
        le_a2b1 = 1'b0;
        a_in = 12'h2D2; a_in_drv = 1'b1; le_a2b2 = 1'b1; b2_oe_n = 1'b0;
        want("R2", 2, 12'h2D2, 1'b1);
        want("R3", 1, 12'h456, 1'b1);
        @(negedge clk);
        a_in_drv = 1'b0; a_in = 12'hBAD;
        want("R8", 2, 12'h2D2, 1'b1);
        @(negedge clk);
        le_a2b2 = 1'b0;
        want("R8", 2, 12'h2D2, 1'b1);

        // sweep select and all three enables with every latch closed
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            sel = i[3]; a_oe_n = i[2]; b1_oe_n = i[1]; b2_oe_n = i[0];
            want_all("R5/R6/R7",
                     i[2] ? 12'h000 : (i[3] ? 12'h456 : 12'h789), ~i[2],
                     i[1] ? 12'h000 : 12'h456, ~i[1],
                     i[0] ? 12'h000 : 12'h2D2, ~i[0]);
        end

        repeat (2) @(negedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule